// File: doc/BRIEF.md
# Write Burst Termination Sequencer

This block sits on the controller side of a synchronous graphics DRAM, one instance per bank. It accepts write, read and precharge requests through a ready/valid handshake. It drives the command code, the DQ output enable and the DQM mask for that bank. A write burst can be cut short in two ways, and the sequencer keeps the bus legal in both:

- **Read.** A read request ends the burst at once. The sequencer then lets CAS latency pass and marks the returning read beats.
- **Precharge.** A precharge request also ends the burst. The precharge command itself is delayed until the write recovery spacing has elapsed. The beats that were abandoned are masked with DQM.

Write recovery time and clock period are parameters in picoseconds. The spacing in whole clocks is derived from them at elaboration by rounding up. Burst length, CAS latency and the single-write option are static configuration inputs. They may only change while the block is idle. Every output is registered, so a request accepted in cycle t produces its command in cycle t+1.

Top module: `wbt_seq`

## Requirements
- R1: A write accepted in cycle t gives command code 1 (WRITE) in cycle t+1. It drives `dq_oe` high for WBL consecutive cycles from t+1, with `wr_beat` counting 0, 1, 2 and so on. WBL is 1, 2, 4 or 8 for `cfg_bl_code` 0, 1, 2 or 3.
- R2: With `cfg_wr_single` high, every write drives exactly one beat, whatever `cfg_bl_code` holds.
- R3: A read accepted in cycle t gives command code 2 (READ) in cycle t+1. `rd_valid` is high for exactly BL cycles, starting in cycle t+1+CL, with `rd_beat` counting 0 to BL-1. CL is `cfg_cas` (1 to 3) and BL is decoded from `cfg_bl_code`.
- R4: A read accepted during a write burst ends that burst. `dq_oe` is low from the READ command cycle onward, and the remaining beats are never driven.
- R5: `dq_oe` is low in the cycle in which `rd_valid` is high and also in the cycle before it.
- R6: Let d be the last cycle with `dq_oe` high and a the cycle in which a precharge request is accepted. Command code 3 (PRECHARGE) then appears in cycle max(a+1, d+M), where M is the write recovery time divided by the clock period, rounded up.
- R7: A precharge accepted during a write burst ends the burst. `dq_oe` is low from cycle a+1 onward.
- R8: If the ended burst still had beats due after cycle a and WBL is greater than 2, `dqm` is high from cycle a+1 through the PRECHARGE cycle, and low in the cycle after it.
- R9: If WBL is 1 or 2, `dqm` stays low during a precharge that ends a write.
- R10: `req_ready` is low while a precharge waits for its spacing, and while read data beyond the next cycle is still due. A request held valid is accepted in the first cycle with `req_ready` high and yields exactly one command.
- R11: During reset and in the first cycle after it, `cmd_o` is 0 (NOP) and `dq_oe`, `dqm` and `rd_valid` are low. `req_ready` is low while reset is asserted and high once it has been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_bl_code | input | 2 | Burst length code: BL = 1 << code |
| cfg_cas | input | 2 | CAS latency, 1 to 3 clocks |
| cfg_wr_single | input | 1 | Writes use a single beat regardless of BL |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 1 write, 2 read, 3 precharge |
| req_ready | output | 1 | Request taken when high together with req_valid |
| cmd_o | output | 2 | 0 NOP, 1 WRITE, 2 READ, 3 PRECHARGE |
| dq_oe | output | 1 | Controller drives write data on DQ |
| wr_beat | output | BEAT_W | Index of the write beat being driven |
| dqm | output | 1 | Data mask |
| rd_valid | output | 1 | Read data is on DQ this cycle |
| rd_beat | output | BEAT_W | Index of the read beat on DQ |

## Verification
The bench builds the block with a 20000 ps write recovery time and an 8000 ps clock. That gives a fractional ratio, so M comes out at 3 only if the ceiling is taken. Three clocks of spacing leave a two-cycle window after an early precharge in which DQM must hold, and in which requests must stall. The default BEAT_W of 3 allows bursts of eight. That makes the single-write override visible, and it lets a burst of four be ended after one beat by either a read or a precharge. CAS latencies 1, 2 and 3 are each run to show the read window moving against the released bus.

// File: rtl/wbt_pkg.sv
package wbt_pkg;

  typedef enum logic [1:0] {
    OP_NOP   = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_PRE   = 2'd3
  } op_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/wbt_wr_beats.sv
module wbt_wr_beats #(
  parameter int BEAT_W = 3,
  localparam int LEN_W = BEAT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              kill,
  input  logic [LEN_W-1:0]  len,
  output logic              oe,
  output logic              oe_next,
  output logic              more,
  output logic [BEAT_W-1:0] beat
);

  logic [LEN_W-1:0]  left_q, left_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              en;

  always_comb begin
    left_d = left_q;
    beat_d = beat_q;
    if (start) begin
      left_d = len;
      beat_d = '0;
    end else if (kill) begin
      left_d = '0;
    end else if (left_q != '0) begin
      left_d = left_q - 1'b1;
      beat_d = beat_q + 1'b1;
    end
  end

  assign en = start | kill | (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      beat_q <= '0;
    end else if (en) begin
      left_q <= left_d;
      beat_q <= beat_d;
    end
  end

  assign oe      = (left_q != '0);
  assign oe_next = (left_d != '0);
  assign more    = (left_q > LEN_W'(1));
  assign beat    = beat_q;

endmodule

// File: rtl/wbt_rd_return.sv
module wbt_rd_return #(
  parameter int BEAT_W = 3,
  localparam int LEN_W = BEAT_W + 1,
  localparam int CNT_W = $clog2(3 + (1 << BEAT_W) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cas,
  input  logic [LEN_W-1:0]  len,
  output logic              valid,
  output logic              busy,
  output logic [BEAT_W-1:0] beat
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             en;

  always_comb begin
    cnt_d = cnt_q;
    if (start)
      cnt_d = CNT_W'(cas) + CNT_W'(len);
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  assign en = start | (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (en)
      cnt_q <= cnt_d;
  end

  assign valid = (cnt_q != '0) && (cnt_q <= CNT_W'(len));
  assign busy  = (cnt_q > CNT_W'(1));
  assign beat  = BEAT_W'(CNT_W'(len) - cnt_q);

endmodule

// File: rtl/wbt_pre_ctrl.sv
module wbt_pre_ctrl #(
  parameter int REC = 2,
  localparam int GAP_W = $clog2(REC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic oe_next,
  input  logic mask_start,
  output logic pend,
  output logic fire,
  output logic dqm
);

  logic [GAP_W-1:0] gap_q, gap_d;
  logic             pend_q, pend_d;
  logic             fire_q, fire_d;
  logic             dqm_q, dqm_d;
  logic             armed;

  always_comb begin
    if (oe_next)
      gap_d = '0;
    else if (gap_q >= GAP_W'(REC))
      gap_d = GAP_W'(REC);
    else
      gap_d = gap_q + 1'b1;
    armed  = pend_q | accept;
    fire_d = armed & (gap_d >= GAP_W'(REC));
    pend_d = armed & ~fire_d;
    dqm_d  = mask_start | (dqm_q & ~fire_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= GAP_W'(REC);
      pend_q <= 1'b0;
      fire_q <= 1'b0;
      dqm_q  <= 1'b0;
    end else begin
      gap_q  <= gap_d;
      pend_q <= pend_d;
      fire_q <= fire_d;
      dqm_q  <= dqm_d;
    end
  end

  assign pend = pend_q;
  assign fire = fire_q;
  assign dqm  = dqm_q;

endmodule

// File: rtl/wbt_seq.sv
module wbt_seq
  import wbt_pkg::*;
#(
  parameter int TWR_PS = 15000,
  parameter int TCK_PS = 8000,
  parameter int BEAT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_bl_code,
  input  logic [1:0]        cfg_cas,
  input  logic              cfg_wr_single,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  output logic              req_ready,
  output logic [1:0]        cmd_o,
  output logic              dq_oe,
  output logic [BEAT_W-1:0] wr_beat,
  output logic              dqm,
  output logic              rd_valid,
  output logic [BEAT_W-1:0] rd_beat
);

  localparam int LEN_W   = BEAT_W + 1;
  localparam int REC_RAW = ceil_div(TWR_PS, TCK_PS);
  localparam int REC_CYC = (REC_RAW < 1) ? 1 : REC_RAW;

  logic [1:0]       rst_pipe;
  logic             srst_n;
  logic [LEN_W-1:0] bl_len, wr_len;
  op_e              op, cmd_q, cmd_d;
  logic             accept, wr_start, rd_start, pre_acc;
  logic             wr_oe_next, wr_more, rd_busy;
  logic             pre_pend, pre_fire, mask_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= '0;
    else
      rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  assign bl_len = LEN_W'(1) << cfg_bl_code;
  assign wr_len = cfg_wr_single ? LEN_W'(1) : bl_len;

  assign op        = op_e'(req_op);
  assign req_ready = srst_n & ~pre_pend & ~rd_busy;
  assign accept    = req_valid & req_ready;
  assign wr_start  = accept & (op == OP_WRITE);
  assign rd_start  = accept & (op == OP_READ);
  assign pre_acc   = accept & (op == OP_PRE);
  assign mask_start = pre_acc & wr_more & (wr_len > LEN_W'(2));

  always_comb begin
    cmd_d = OP_NOP;
    if (wr_start)
      cmd_d = OP_WRITE;
    else if (rd_start)
      cmd_d = OP_READ;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)
      cmd_q <= OP_NOP;
    else
      cmd_q <= cmd_d;
  end

  assign cmd_o = pre_fire ? OP_PRE : cmd_q;

  wbt_wr_beats #(.BEAT_W(BEAT_W)) u_wr (
    .clk     (clk),
    .rst_n   (srst_n),
    .start   (wr_start),
    .kill    (rd_start | pre_acc),
    .len     (wr_len),
    .oe      (dq_oe),
    .oe_next (wr_oe_next),
    .more    (wr_more),
    .beat    (wr_beat)
  );

  wbt_rd_return #(.BEAT_W(BEAT_W)) u_rd (
    .clk   (clk),
    .rst_n (srst_n),
    .start (rd_start),
    .cas   (cfg_cas),
    .len   (bl_len),
    .valid (rd_valid),
    .busy  (rd_busy),
    .beat  (rd_beat)
  );

  wbt_pre_ctrl #(.REC(REC_CYC)) u_pre (
    .clk        (clk),
    .rst_n      (srst_n),
    .accept     (pre_acc),
    .oe_next    (wr_oe_next),
    .mask_start (mask_start),
    .pend       (pre_pend),
    .fire       (pre_fire),
    .dqm        (dqm)
  );

endmodule

// File: rtl/wbt_seq_chk.sv
module wbt_seq_chk #(
  parameter int REC = 2,
  localparam int SW = $clog2(REC + 1) + 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cmd,
  input logic       dq_oe,
  input logic       dqm,
  input logic       rd_valid
);

  logic [SW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      since_q <= SW'(REC);
    else if (dq_oe)
      since_q <= SW'(1);
    else if (since_q < SW'(REC))
      since_q <= since_q + 1'b1;
  end

  // R1
  write_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'd1) |-> dq_oe);

  // R4
  read_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'd2) |-> !dq_oe);

  // R5
  bus_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (!dq_oe && !$past(dq_oe)));

  // R6
  pre_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 2'd3) |-> (since_q >= SW'(REC)));

  // R8
  mask_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dqm) |-> ($past(cmd) == 2'd3));

  // R8
  mask_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dqm |-> !dq_oe);

endmodule

bind wbt_seq wbt_seq_chk #(.REC(REC_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (srst_n),
  .cmd      (cmd_o),
  .dq_oe    (dq_oe),
  .dqm      (dqm),
  .rd_valid (rd_valid)
);

// File: tb/wbt_seq_test.sv
`timescale 1ns/1ps
module wbt_seq_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cfg_bl_code, cfg_cas;
  logic       cfg_wr_single;
  logic       req_valid;
  logic [1:0] req_op;
  logic       req_ready, dq_oe, dqm, rd_valid;
  logic [1:0] cmd_o;
  logic [2:0] wr_beat, rd_beat;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #4 clk = ~clk;

  wbt_seq #(.TWR_PS(20000), .TCK_PS(8000), .BEAT_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_bl_code(cfg_bl_code), .cfg_cas(cfg_cas),
    .cfg_wr_single(cfg_wr_single), .req_valid(req_valid), .req_op(req_op),
    .req_ready(req_ready), .cmd_o(cmd_o), .dq_oe(dq_oe), .wr_beat(wr_beat),
    .dqm(dqm), .rd_valid(rd_valid), .rd_beat(rd_beat)
  );

  // row: {valid, op[1:0], cmd[1:0], oe, dqm, rd_valid, ready}; BL=4, CL=2, M=3
  localparam logic [8:0] VEC [25] = '{
    9'b0_00_00_0_0_0_1, 9'b1_01_00_0_0_0_1, 9'b1_10_01_1_0_0_1, 9'b0_00_10_0_0_0_0,
    9'b0_00_00_0_0_0_0, 9'b0_00_00_0_0_1_0, 9'b0_00_00_0_0_1_0, 9'b0_00_00_0_0_1_0,
    9'b0_00_00_0_0_1_1, 9'b0_00_00_0_0_0_1, 9'b1_01_00_0_0_0_1, 9'b1_11_01_1_0_0_1,
    9'b0_00_00_0_1_0_0, 9'b0_00_00_0_1_0_0, 9'b0_00_11_0_1_0_1, 9'b0_00_00_0_0_0_1,
    9'b1_01_00_0_0_0_1, 9'b0_00_01_1_0_0_1, 9'b0_00_00_1_0_0_1, 9'b0_00_00_1_0_0_1,
    9'b1_11_00_1_0_0_1, 9'b0_00_00_0_0_0_0, 9'b0_00_00_0_0_0_0, 9'b0_00_11_0_0_0_1,
    9'b0_00_00_0_0_0_1
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    req_valid = 1'b0;
    req_op    = 2'd0;
    repeat (n) cyc();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int acc_at;
    int wr_seen;
    rst_n = 1'b0; cfg_bl_code = 2'd2; cfg_cas = 2'd2; cfg_wr_single = 1'b0;
    req_valid = 1'b0; req_op = 2'd0;
    repeat (3) cyc();
    check("R11 ready in reset", req_ready, 0);
    check("R11 cmd in reset", cmd_o, 0);
    rst_n = 1'b1;
    repeat (3) cyc();
    check("R11 outputs after reset", {cmd_o, dq_oe, dqm, rd_valid}, 0);
    check("R11 ready after reset", req_ready, 1);

    // table: read cuts write (R4), early precharge (R8), late precharge (R6)
    for (int k = 0; k < 25; k++) begin
      req_valid = VEC[k][8];
      req_op    = VEC[k][7:6];
      check(k < 10 ? "R4 vector" : (k < 16 ? "R8 vector" : "R6 vector"),
            {cmd_o, dq_oe, dqm, rd_valid, req_ready}, VEC[k][5:0]);
      cyc();
    end
    idle(4);

    // R1: burst of eight with beat indices
    cfg_bl_code = 2'd3;
    req_valid = 1'b1; req_op = 2'd1;
    cyc();
    req_valid = 1'b0;
    check("R1 write cmd", cmd_o, 1);
    for (int i = 0; i < 8; i++) begin
      check("R1 oe", dq_oe, 1);
      check("R1 beat", wr_beat, i);
      cyc();
    end
    check("R1 oe after burst", dq_oe, 0);
    idle(3);

    // R2: single-write mode
    cfg_wr_single = 1'b1;
    req_valid = 1'b1; req_op = 2'd1;
    cyc();
    req_valid = 1'b0;
    check("R2 first beat", dq_oe, 1);
    cyc();
    check("R2 no second beat", dq_oe, 0);
    cfg_wr_single = 1'b0;
    idle(4);

    // R9 and R7: BL=2 precharge cut, mask stays low, spacing M=3
    cfg_bl_code = 2'd1;
    req_valid = 1'b1; req_op = 2'd1;
    cyc();
    check("R7 oe beat0", dq_oe, 1);
    req_op = 2'd3;
    cyc();
    req_valid = 1'b0;
    check("R7 oe stopped", dq_oe, 0);
    check("R9 dqm c2", dqm, 0);
    check("R10 ready pend", req_ready, 0);
    cyc();
    check("R9 dqm c3", dqm, 0);
    check("R6 no early pre", cmd_o, 0);
    cyc();
    check("R6 pre issued", cmd_o, 3);
    check("R9 dqm at pre", dqm, 0);
    idle(3);

    // R3: CL=1, BL=2
    cfg_cas = 2'd1;
    req_valid = 1'b1; req_op = 2'd2;
    cyc();
    req_valid = 1'b0;
    check("R3 read cmd", cmd_o, 2);
    check("R3 cl1 no data yet", rd_valid, 0);
    cyc();
    check("R3 cl1 beat0 valid", rd_valid, 1);
    check("R3 cl1 beat0", rd_beat, 0);
    cyc();
    check("R3 cl1 beat1 valid", rd_valid, 1);
    check("R3 cl1 beat1", rd_beat, 1);
    cyc();
    check("R3 cl1 end", rd_valid, 0);
    idle(3);

    // R3: CL=3, BL=4
    cfg_cas = 2'd3; cfg_bl_code = 2'd2;
    req_valid = 1'b1; req_op = 2'd2;
    cyc();
    req_valid = 1'b0;
    for (int i = 1; i <= 8; i++) begin
      check("R3 cl3 window", rd_valid, (i >= 4 && i <= 7) ? 1 : 0);
      if (i >= 4 && i <= 7) check("R3 cl3 beat", rd_beat, i - 4);
      cyc();
    end
    idle(3);

    // R10: write held valid during read return is taken once when ready
    cfg_cas = 2'd2;
    req_valid = 1'b1; req_op = 2'd2;
    cyc();
    req_op = 2'd1;
    acc_at = -1; wr_seen = 0;
    for (int i = 1; i <= 10; i++) begin
      if (acc_at < 0 && req_ready) acc_at = i;
      cyc();
      if (cmd_o == 2'd1) wr_seen++;
      if (acc_at == i) begin
        req_valid = 1'b0;
        check("R10 write cmd after accept", cmd_o, 1);
      end
    end
    check("R10 accept cycle", acc_at, 6);
    check("R10 single write cmd", wr_seen, 1);
    idle(10);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule